// File: doc/BRIEF.md
# Masked Parallel GPIO Data Unit

This block holds the output values of a bank of pads and samples their input values. Software reaches it through a small 32-bit register bus. Every pad can be seen three ways: one register per pad, packed 16-bit groups, and masked group writes. A masked write carries a 16-bit select mask and 16 bits of data in the same word. Software can therefore set, clear or load any subset of one output group in a single write, with no read-modify-write sequence and no race against other code that touches the same group.

The pads are arranged in `NUM_GROUPS` groups of 16; group g covers pad indices g*16 to g*16+15. Each bus request is accepted in one cycle. The response (valid, error flag and read data) appears on the following cycle, and any output change lands on that same edge. Pad inputs pass through a two-stage synchronizer before any register view can see them. The per-pad input view and the packed input view both read that synchronized copy, so they always agree.

Register map (byte offsets; every register is 32 bits and word aligned). With the default of 7 groups the block has 112 pads and 4 packed words.

| Region | Offset of entry n | Entries |
|---|---|---|
| Per-pad output value | 0x000 + 4n | one per pad |
| Per-pad input value | 0x200 + 4n | one per pad |
| Packed output word | 0x400 + 4n | ceil(NUM_GROUPS/2) |
| Packed input word | 0x600 + 4n | ceil(NUM_GROUPS/2) |
| Masked group write | 0x800 + 4n | NUM_GROUPS |

The size qualifier `req_size` is encoded as 0 = byte, 1 = halfword, 2 = word.

Top module: `gpio_data_unit`

## Requirements
- R1: A synchronous active-high reset clears every pad output, both synchronizer stages and the response outputs (`rsp_valid`, `rsp_err` and `rsp_rdata` all read 0).
- R2: A word-size write to masked register x (offset 0x800+4x, x < NUM_GROUPS) works on the pads of group x. For each bit y, if wdata[16+y] is 1, pad x*16+y takes the value of wdata[y]; if wdata[16+y] is 0, that pad keeps its value. All selected pads change on the same clock edge that returns the response.
- R3: A byte-size (0) or halfword-size (1) write to a masked register leaves every pad output unchanged and returns an error response.
- R4: A read of a masked register returns 0 without an error.
- R5: Per-pad output register p (offset 0x000+4p) sets pad p to the value of wdata[0] when written. When read, it returns that pad's output in bit 0, with all other bits 0.
- R6: Packed output word k (offset 0x400+4k) holds group 2k in bits [31:16] and group 2k+1 in bits [15:0]. Within a group, bit y is pad g*16+y. Writes load both groups and reads return them. A halfword that names a group beyond NUM_GROUPS is ignored on write and reads as 0.
- R7: Packed input word k (offset 0x600+4k) returns the synchronized inputs of group 2k in bits [31:16] and of group 2k+1 in bits [15:0]. Bit y of group g is pad g*16+y, and a group beyond NUM_GROUPS reads as 0.
- R8: A read reflects a pad input change only after two clock edges. If a read request is presented in the same cycle as the input change, or one cycle later, it returns the old value. A read presented two cycles later returns the new value.
- R9: Per-pad input register p (offset 0x200+4p) returns the synchronized input of pad p in bit 0, equal to the matching bit of the packed input view.
- R10: A write to any input register returns an error response and changes no pad output.
- R11: An access to an address that is misaligned, lies past the last entry of its region, or lies outside every region returns an error response with read data 0 and changes no pad output.
- R12: Every request gives exactly one response, with `rsp_valid` high on the next cycle. Writes and error responses return read data 0.
- R13: Per-pad and packed output registers accept writes of any size and treat them as full-word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_err | output | 1 | Transfer error response |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_GROUPS*16 | Raw pad input values |
| pad_out | output | NUM_GROUPS*16 | Pad output values |

## Verification
Masked writes are swept over every group with masks that are all ones, all zeros, a single byte, and values generated arithmetically. This separates mask bits that are ignored, bits that are applied to the wrong group, and a swap of the mask and data halves. Narrow masked writes are tried at every group, and reads of the masked registers are tried at every group. Input patterns of all ones, alternating bits and an index-derived formula are read through both the packed and the per-pad input views. A read issued zero, one and two cycles after an input change exposes a synchronizer that is too short or too long. Writes to the input registers, writes to unmapped, out-of-range and misaligned addresses, and packed writes to the absent upper group show whether each is rejected or ignored as required.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GRP_W = 16;
    localparam int AW    = 12;
    localparam int DW    = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    // Region number equals address bits [11:9]
    typedef enum logic [2:0] {
        RG_BIT_OUT = 3'd0,
        RG_BIT_IN  = 3'd1,
        RG_PAR_OUT = 3'd2,
        RG_PAR_IN  = 3'd3,
        RG_MASK    = 3'd4,
        RG_NONE    = 3'd7
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [6:0] idx;
    } dec_t;

    function automatic logic [GRP_W-1:0] merge_masked(
        input logic [GRP_W-1:0] cur,
        input logic [GRP_W-1:0] data,
        input logic [GRP_W-1:0] sel
    );
        return (cur & ~sel) | (data & sel);
    endfunction

    function automatic logic is_word(input logic [1:0] sz);
        return sz == SZ_WORD;
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int NUM_GROUPS = 7
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int NPADS = NUM_GROUPS * GRP_W;
    localparam int NPAR  = (NUM_GROUPS + 1) / 2;

    logic [6:0] idx;
    assign idx = addr[8:2];

    always_comb begin
        dec.idx    = idx;
        dec.region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (addr[11:9])
                3'd0: if (int'(idx) < NPADS)      dec.region = RG_BIT_OUT;
                3'd1: if (int'(idx) < NPADS)      dec.region = RG_BIT_IN;
                3'd2: if (int'(idx) < NPAR)       dec.region = RG_PAR_OUT;
                3'd3: if (int'(idx) < NPAR)       dec.region = RG_PAR_IN;
                3'd4: if (int'(idx) < NUM_GROUPS) dec.region = RG_MASK;
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 112
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
#(
    parameter int NUM_GROUPS = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_bit,
    input  logic                        wr_par,
    input  logic                        wr_mask,
    input  logic [6:0]                  idx,
    input  logic [DW-1:0]               wdata,
    output logic [NUM_GROUPS*GRP_W-1:0] pad_out
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GRP_W-1:0] q, nxt;
        logic [GRP_W-1:0] par_half;

        if (g % 2 == 0) begin : g_hi
            assign par_half = wdata[31:16];
        end else begin : g_lo
            assign par_half = wdata[15:0];
        end

        always_comb begin
            nxt = q;
            if (wr_mask && int'(idx) == g)
                nxt = merge_masked(q, wdata[15:0], wdata[31:16]);
            if (wr_par && int'(idx) == g / 2)
                nxt = par_half;
            if (wr_bit && int'(idx[6:4]) == g)
                nxt[idx[3:0]] = wdata[0];
        end

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= nxt;
        end

        assign pad_out[g*GRP_W +: GRP_W] = q;
    end

    // R2
    mask_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && wdata[31:16] == '0) |=> $stable(pad_out));

    // R2
    mask_all_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && wdata[31:16] == '1 && int'(idx) < NUM_GROUPS)
        |=> pad_out[int'($past(idx))*GRP_W +: GRP_W] == $past(wdata[15:0]));
endmodule

// File: rtl/gpio_data_unit.sv
module gpio_data_unit
    import gpio_pkg::*;
#(
    parameter int NUM_GROUPS = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [11:0]                 req_addr,
    input  logic [1:0]                  req_size,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [31:0]                 rsp_rdata,
    input  logic [NUM_GROUPS*16-1:0]    pad_in,
    output logic [NUM_GROUPS*16-1:0]    pad_out
);
    localparam int NPADS = NUM_GROUPS * GRP_W;
    localparam int NPAR  = (NUM_GROUPS + 1) / 2;

    dec_t             dec;
    logic [NPADS-1:0] in_s;
    logic             bad, wr_ok;
    logic [DW-1:0]    rd;
    logic [DW-1:0]    out_word [NPAR];
    logic [DW-1:0]    in_word  [NPAR];

    gpio_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    gpio_in_sync #(.W(NPADS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (in_s)
    );

    always_comb begin
        bad = (dec.region == RG_NONE);
        if (req_write && (dec.region == RG_BIT_IN || dec.region == RG_PAR_IN))
            bad = 1'b1;
        if (req_write && dec.region == RG_MASK && !is_word(req_size))
            bad = 1'b1;
    end

    assign wr_ok = req_valid && req_write && !bad;

    gpio_out_regs #(.NUM_GROUPS(NUM_GROUPS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .wr_bit  (wr_ok && dec.region == RG_BIT_OUT),
        .wr_par  (wr_ok && dec.region == RG_PAR_OUT),
        .wr_mask (wr_ok && dec.region == RG_MASK),
        .idx     (dec.idx),
        .wdata   (req_wdata),
        .pad_out (pad_out)
    );

    for (genvar k = 0; k < NPAR; k++) begin : g_pack
        assign out_word[k][31:16] = pad_out[2*k*GRP_W +: GRP_W];
        assign in_word[k][31:16]  = in_s[2*k*GRP_W +: GRP_W];
        if (2*k + 1 < NUM_GROUPS) begin : g_lo
            assign out_word[k][15:0] = pad_out[(2*k+1)*GRP_W +: GRP_W];
            assign in_word[k][15:0]  = in_s[(2*k+1)*GRP_W +: GRP_W];
        end else begin : g_none
            assign out_word[k][15:0] = '0;
            assign in_word[k][15:0]  = '0;
        end
    end

    always_comb begin
        rd = '0;
        unique case (dec.region)
            RG_BIT_OUT: rd[0] = pad_out[dec.idx];
            RG_BIT_IN:  rd[0] = in_s[dec.idx];
            RG_PAR_OUT: rd = out_word[dec.idx[$clog2(NPAR+1)-1:0]];
            RG_PAR_IN:  rd = in_word[dec.idx[$clog2(NPAR+1)-1:0]];
            default:    rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && bad;
            rsp_rdata <= (req_valid && !req_write && !bad) ? rd : '0;
        end
    end

    // R3
    narrow_mask_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && dec.region == RG_MASK && !is_word(req_size))
        |=> (rsp_err && $stable(pad_out)));

    // R4
    mask_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && dec.region == RG_MASK)
        |=> (rsp_rdata == '0 && !rsp_err));

    // R11
    unmapped_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.region == RG_NONE)
        |=> (rsp_err && rsp_rdata == '0 && $stable(pad_out)));

    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R12
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/tb_gpio_data_unit.sv
module tb_gpio_data_unit;
    localparam int NG    = 7;
    localparam int NP    = NG * 16;
    localparam int NPAR  = (NG + 1) / 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid, req_write;
    logic [11:0]     req_addr;
    logic [1:0]      req_size;
    logic [31:0]     req_wdata;
    logic            rsp_valid, rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NP-1:0]   pad_in, pad_out;

    int vectors = 0;
    int miscompares = 0;
    logic [NP-1:0] m_out;

    always #2.5 clk = ~clk;

    gpio_data_unit #(.NUM_GROUPS(NG)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out)
    );

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the response.
    task automatic bus(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        chk("R12 rsp_valid", 128'(rsp_valid), 128'(1));
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] model_par_out(input int k);
        logic [31:0] w;
        w[31:16] = m_out[2*k*16 +: 16];
        w[15:0]  = (2*k + 1 < NG) ? m_out[(2*k+1)*16 +: 16] : 16'h0;
        return w;
    endfunction

    function automatic logic [31:0] model_par_in(input int k, input logic [NP-1:0] v);
        logic [31:0] w;
        w[31:16] = v[2*k*16 +: 16];
        w[15:0]  = (2*k + 1 < NG) ? v[(2*k+1)*16 +: 16] : 16'h0;
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [31:0] rd;
        logic        er;
        logic [15:0] mk, dt;
        logic [NP-1:0] pv, old_in;

        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = 2'd2; req_wdata = '0; pad_in = '0; m_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pad_out", 128'(pad_out), 128'(0));
        chk("R1 rsp_valid", 128'(rsp_valid), 128'(0));
        chk("R1 rsp_err", 128'(rsp_err), 128'(0));
        chk("R1 rsp_rdata", 128'(rsp_rdata), 128'(0));

        // R2 masked write sweep
        for (int x = 0; x < NG; x++) begin
            for (int p = 0; p < 6; p++) begin
                case (p)
                    0: begin mk = 16'hFFFF; dt = 16'(16'h1234 + x * 16'h1111); end
                    1: begin mk = 16'h0000; dt = 16'hFFFF; end
                    2: begin mk = 16'h00FF; dt = 16'hFFFF; end
                    3: begin mk = 16'hFF00; dt = 16'h0000; end
                    default: begin
                        mk = 16'(16'h9E37 * (p + 1) + x * 16'h0101);
                        dt = 16'(16'h5AC3 ^ (x * 16'h0F1D + p));
                    end
                endcase
                bus(1'b1, 12'(12'h800 + 4 * x), 2'd2, {mk, dt}, rd, er);
                m_out[x*16 +: 16] = (m_out[x*16 +: 16] & ~mk) | (dt & mk);
                chk("R2 masked err", 128'(er), 128'(0));
                chk("R2 masked pad_out", 128'(pad_out), 128'(m_out));
            end
        end

        // R4 masked reads return zero
        for (int x = 0; x < NG; x++) begin
            bus(1'b0, 12'(12'h800 + 4 * x), 2'd2, 32'h0, rd, er);
            chk("R4 masked read data", 128'(rd), 128'(0));
            chk("R4 masked read err", 128'(er), 128'(0));
        end

        // R3 narrow masked writes rejected
        for (int x = 0; x < NG; x++) begin
            for (int s = 0; s < 2; s++) begin
                bus(1'b1, 12'(12'h800 + 4 * x), 2'(s), {16'hFFFF, ~m_out[x*16 +: 16]}, rd, er);
                chk("R3 narrow err", 128'(er), 128'(1));
                chk("R3 narrow pad_out", 128'(pad_out), 128'(m_out));
            end
        end

        // R6 packed output read back
        for (int k = 0; k < NPAR; k++) begin
            bus(1'b0, 12'(12'h400 + 4 * k), 2'd2, 32'h0, rd, er);
            chk("R6 packed read", 128'(rd), 128'(model_par_out(k)));
        end
        // R6 / R13 packed writes, some narrow-size
        for (int k = 0; k < NPAR; k++) begin
            logic [31:0] w;
            w = 32'(32'hC0DE_0000 + k * 32'h0101_3579);
            bus(1'b1, 12'(12'h400 + 4 * k), 2'(k % 3), w, rd, er);
            m_out[2*k*16 +: 16] = w[31:16];
            if (2*k + 1 < NG) m_out[(2*k+1)*16 +: 16] = w[15:0];
            chk("R13 packed write err", 128'(er), 128'(0));
            chk("R6 packed write pad_out", 128'(pad_out), 128'(m_out));
            bus(1'b0, 12'(12'h400 + 4 * k), 2'd2, 32'h0, rd, er);
            chk("R6 packed readback", 128'(rd), 128'(model_par_out(k)));
        end

        // R5 / R13 per-pad output registers
        for (int p = 0; p < NP; p += 5) begin
            logic b;
            b = ~m_out[p];
            bus(1'b1, 12'(4 * p), 2'(p % 2), {31'h7FFF_FFFE, b}, rd, er);
            m_out[p] = b;
            chk("R5 bit write pad_out", 128'(pad_out), 128'(m_out));
            bus(1'b0, 12'(4 * p), 2'd2, 32'h0, rd, er);
            chk("R5 bit readback", 128'(rd), 128'({31'h0, b}));
        end

        // R8 synchronizer latency
        pv = '0;
        for (int i = 0; i < NP; i++) pv[i] = ((i * 7 + 3) % 5) < 2;
        old_in = pad_in;
        pad_in = pv;
        bus(1'b0, 12'h600, 2'd2, 32'h0, rd, er);
        chk("R8 read at change", 128'(rd), 128'(model_par_in(0, old_in)));
        bus(1'b0, 12'h600, 2'd2, 32'h0, rd, er);
        chk("R8 read one later", 128'(rd), 128'(model_par_in(0, old_in)));
        bus(1'b0, 12'h600, 2'd2, 32'h0, rd, er);
        chk("R8 read two later", 128'(rd), 128'(model_par_in(0, pv)));

        // R7 / R9 input views under several patterns
        for (int pat = 0; pat < 3; pat++) begin
            pv = '0;
            for (int i = 0; i < NP; i++)
                pv[i] = (pat == 0) ? 1'b1 : (pat == 1) ? i[0] : (((i * 7 + 3) % 5) < 2);
            pad_in = pv;
            repeat (2) @(negedge clk);
            for (int k = 0; k < NPAR; k++) begin
                bus(1'b0, 12'(12'h600 + 4 * k), 2'd2, 32'h0, rd, er);
                chk("R7 packed input", 128'(rd), 128'(model_par_in(k, pv)));
            end
            for (int p = 0; p < NP; p++) begin
                bus(1'b0, 12'(12'h200 + 4 * p), 2'd2, 32'h0, rd, er);
                chk("R9 per-pad input", 128'(rd), 128'({31'h0, pv[p]}));
            end
        end

        // R10 writes to input registers
        bus(1'b1, 12'h204, 2'd2, 32'hFFFF_FFFF, rd, er);
        chk("R10 bit-in write err", 128'(er), 128'(1));
        chk("R10 bit-in write pad_out", 128'(pad_out), 128'(m_out));
        bus(1'b1, 12'h600, 2'd2, 32'hFFFF_FFFF, rd, er);
        chk("R10 packed-in write err", 128'(er), 128'(1));
        chk("R10 packed-in write pad_out", 128'(pad_out), 128'(m_out));

        // R11 unmapped, out-of-range and misaligned accesses
        bus(1'b1, 12'hA00, 2'd2, 32'hFFFF_FFFF, rd, er);
        chk("R11 outside err", 128'(er), 128'(1));
        chk("R11 outside pad_out", 128'(pad_out), 128'(m_out));
        bus(1'b1, 12'(4 * NP), 2'd2, 32'h1, rd, er);
        chk("R11 past bit-out err", 128'(er), 128'(1));
        bus(1'b1, 12'(12'h800 + 4 * NG), 2'd2, 32'hFFFF_FFFF, rd, er);
        chk("R11 past mask err", 128'(er), 128'(1));
        bus(1'b1, 12'h801, 2'd2, 32'hFFFF_0000, rd, er);
        chk("R11 misaligned err", 128'(er), 128'(1));
        chk("R11 misaligned pad_out", 128'(pad_out), 128'(m_out));
        bus(1'b0, 12'(12'h400 + 4 * NPAR), 2'd2, 32'h0, rd, er);
        chk("R11 past packed read err", 128'(er), 128'(1));
        chk("R11 past packed read data", 128'(rd), 128'(0));

        // R12 write response carries zero data
        bus(1'b1, 12'h800, 2'd2, 32'h0000_0000, rd, er);
        chk("R12 write rdata", 128'(rd), 128'(0));
        @(negedge clk);
        chk("R12 idle rsp_valid", 128'(rsp_valid), 128'(0));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule